// File: doc/BRIEF.md
# Serial Configuration Memory Programming Interface

This block is the programming side of a one-time-programmable serial configuration memory. A programmer clocks it through a fixed sequence of programming-supply levels to unlock programming mode. From then on the chip-enable and output-enable pins together pick the operation for each rising clock edge. One choice shifts a bit into a 32-bit word latch. Another shifts a bit of the addressed array word out for verification. A third steps the word address. A rising edge of the high programming level burns the latched word into the array.

The high-voltage supply is reduced to two digital levels. `vpp_high` means the burn or entry level is present. `vpp_access` means the lower access level is present. Array cells act like EPROM cells: they start all ones, and a burn can only clear bits. A power-down reset ends programming mode. The array keeps its contents across that reset.

Top module: `sprom_prog_if`

## Requirements
- R1: With ce_n=1 and oe=1 at each edge, two consecutive rising edges with vpp_high=1, then one edge with vpp_access=1 and vpp_high=0, set prog_mode=1 after that third edge. prog_mode then stays 1 until reset.
- R2: Any edge of the entry sequence with the wrong level, or with ce_n or oe low, sends the detector back to idle. The full sequence must then be given again from its start.
- R3: In programming mode, each edge with ce_n=1 and oe=1 shifts data_in into bit 0 of the word latch and moves every other bit up one place. After 32 such edges the first bit shifted lands in bit 31.
- R4: In programming mode with ce_n=0 and oe=1, data_oe is 1 and data_out shows bit 31-k of the addressed word, where k is the number of edges since the edge that saw ce_n fall. data_oe is 0 in every other state.
- R5: In programming mode, each edge with ce_n=1 and oe=0 adds one to the word address, which wraps from 15 back to 0 at the default size.
- R6: An edge that sees ce_n go from 1 to 0 sets the word latch to all ones and restarts the readout at bit 31. A burn of that cleared latch leaves the array unchanged.
- R7: In programming mode, an edge where vpp_high is 1 after being 0 at the previous edge replaces the addressed word with its bitwise AND with the latch value from before that edge. This holds even when the same edge also shifts the latch or steps the address.
- R8: In programming mode, chain_out equals pol_hi and pol_hi has no effect on how oe is decoded. Outside programming mode chain_out is 1.
- R9: Reset sets prog_mode=0, data_oe=0, data_out=0, the address to 0 and the latch to all ones. Array contents are kept.
- R10: Outside programming mode, the pins ce_n, oe and data_in and toggling of vpp_high that does not complete the entry sequence neither drive data nor change the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock, rising edge active |
| rst_n | input | 1 | Power-down reset, active low |
| ce_n | input | 1 | Chip-enable pin level |
| oe | input | 1 | Output-enable / reset pin level |
| vpp_high | input | 1 | Programming supply at burn level |
| vpp_access | input | 1 | Programming supply at access level |
| pol_hi | input | 1 | Stored reset polarity, 1 = active high |
| data_in | input | 1 | Serial data bit from the programmer |
| data_out | output | 1 | Serial verify data bit |
| data_oe | output | 1 | Drive enable for data_out |
| prog_mode | output | 1 | Programming mode active |
| chain_out | output | 1 | Cascade output; reports polarity in programming mode |

## Verification
A burn strobe can fall on the same edge as a latch shift, or on the same edge as an address step. The bench creates the first case by shifting only 31 bits and raising vpp_high on the edge that carries the 32nd bit. It creates the second case by raising vpp_high while ce_n=1 and oe=0. In both cases the burned value is predicted from the latch and address that held before the edge. The bench then reads the words back serially: the second case is checked at the old address after the address wraps around. Random words that are burned twice at one address also check that burns only clear bits.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

  typedef enum logic [1:0] {
    ENT_IDLE = 2'd0,
    ENT_HI1  = 2'd1,
    ENT_HI2  = 2'd2,
    ENT_PROG = 2'd3
  } ent_state_t;

  // one step of the unlock sequence; any off-pattern edge falls back to idle
  function automatic ent_state_t ent_step(ent_state_t s, logic sel_ok,
                                          logic vh, logic va);
    case (s)
      ENT_IDLE: return (sel_ok && vh) ? ENT_HI1 : ENT_IDLE;
      ENT_HI1:  return (sel_ok && vh) ? ENT_HI2 : ENT_IDLE;
      ENT_HI2:  return (sel_ok && va && !vh) ? ENT_PROG : ENT_IDLE;
      default:  return ENT_PROG;
    endcase
  endfunction

endpackage

// File: rtl/sprom_entry_det.sv
module sprom_entry_det
  import sprom_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_hi,
  input  logic oe_hi,
  input  logic vpp_high,
  input  logic vpp_access,
  output logic prog
);

  ent_state_t state;
  logic       sel_ok;

  assign sel_ok = ce_hi && oe_hi;
  assign prog   = (state == ENT_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ENT_IDLE;
    else        state <= ent_step(state, sel_ok, vpp_high, vpp_access);
  end

  // R1: mode only opens on an access-level edge with both pins high
  a_r1_entry_last_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog) |-> $past(vpp_access && !vpp_high && ce_hi && oe_hi));

  // R1: mode is sticky until reset
  a_r1_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> prog);

  // R2: a wrong final step never opens the mode
  a_r2_broken_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENT_HI2 && !(sel_ok && vpp_access && !vpp_high)) |=> !prog);

endmodule

// File: rtl/sprom_word_latch.sv
module sprom_word_latch #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              ce_hi,
  input  logic              oe_hi,
  input  logic              ce_fall,
  input  logic              din,
  output logic [WORD_W-1:0] word
);

  logic shift_en;
  assign shift_en = prog && ce_hi && oe_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                word <= '1;
    else if (prog && ce_fall)  word <= '1;
    else if (shift_en)         word <= {word[WORD_W-2:0], din};
  end

  // R6: a chip-enable fall leaves the latch cleared to ones
  a_r6_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (prog && ce_fall) |=> (word == '1));

  // R3: each shift edge takes the serial bit into the low end
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(din)) &&
                 (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));

endmodule

// File: rtl/sprom_cell_array.sv
module sprom_cell_array #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [$clog2(WORD_W)-1:0] bit_idx,
  output logic                      rd_bit
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BIT_W = $clog2(WORD_W);

  // EPROM rule: a burn can only pull bits low
  function automatic logic [WORD_W-1:0] burn(logic [WORD_W-1:0] old_w,
                                             logic [WORD_W-1:0] new_w);
    return old_w & new_w;
  endfunction

  // serial readout is most significant bit first
  function automatic logic pick_bit(logic [WORD_W-1:0] w, logic [BIT_W-1:0] k);
    return w[BIT_W'(WORD_W - 1) - k];
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];

  // cells leave the factory erased; contents survive the power-down reset
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= burn(mem[addr], wdata);
  end

  assign rd_bit = pick_bit(mem[addr], bit_idx);

  // R7: a burn never sets a bit that was clear
  a_r7_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((mem[$past(addr)] & ~$past(mem[addr])) == '0));

endmodule

// File: rtl/sprom_prog_if.sv
module sprom_prog_if #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe,
  input  logic vpp_high,
  input  logic vpp_access,
  input  logic pol_hi,
  input  logic data_in,
  output logic data_out,
  output logic data_oe,
  output logic prog_mode,
  output logic chain_out
);

  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic              prog;
  logic              ce_q, vh_q;
  logic              ce_fall, strobe, shift_out, addr_step;
  logic [ADDR_W-1:0] addr;
  logic [BIT_W-1:0]  bitc;
  logic [WORD_W-1:0] latch_w;
  logic              rd_bit;

  // named events for the assertions
  assign ce_fall   = ce_q && !ce_n;
  assign strobe    = prog && vpp_high && !vh_q;
  assign shift_out = prog && !ce_n && oe;
  assign addr_step = prog && ce_n && !oe;

  sprom_entry_det u_entry (
    .clk(clk), .rst_n(rst_n), .ce_hi(ce_n), .oe_hi(oe),
    .vpp_high(vpp_high), .vpp_access(vpp_access), .prog(prog)
  );

  sprom_word_latch #(.WORD_W(WORD_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .prog(prog), .ce_hi(ce_n), .oe_hi(oe),
    .ce_fall(ce_fall), .din(data_in), .word(latch_w)
  );

  sprom_cell_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(strobe), .addr(addr),
    .wdata(latch_w), .bit_idx(bitc), .rd_bit(rd_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q <= 1'b1;
      vh_q <= 1'b0;
    end else begin
      ce_q <= ce_n;
      vh_q <= vpp_high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr <= '0;
    else if (addr_step) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                bitc <= '0;
    else if (prog && ce_fall)  bitc <= '0;
    else if (shift_out)        bitc <= (bitc == BIT_LAST) ? '0 : bitc + 1'b1;
  end

  assign data_oe   = shift_out;
  assign data_out  = shift_out ? rd_bit : 1'b0;
  assign prog_mode = prog;
  assign chain_out = prog ? pol_hi : 1'b1;

  // R5: address steps by one, wrapping
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R4: readout only drives inside programming mode
  a_r4_drive_in_mode: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> prog);

  // R6: readout restarts at the top bit after a chip-enable fall
  a_r6_bit_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (prog && ce_fall) |=> (bitc == '0));

  // R8: cascade output idles high outside the mode
  a_r8_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !prog |-> chain_out);

endmodule

// File: tb/tb_sprom_prog_if.sv
`timescale 1ns/1ps
module tb_sprom_prog_if;

  localparam int W = 32;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe, vpp_high, vpp_access, pol_hi, data_in;
  logic data_out, data_oe, prog_mode, chain_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0]  e_mem [DEPTH];
  logic [AW-1:0] e_addr;

  always #2.5 clk = ~clk;

  sprom_prog_if #(.WORD_W(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe(oe), .vpp_high(vpp_high),
    .vpp_access(vpp_access), .pol_hi(pol_hi), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .prog_mode(prog_mode),
    .chain_out(chain_out)
  );

  function automatic logic [W-1:0] and_burn(logic [W-1:0] a, logic [W-1:0] b);
    return a & b;
  endfunction

  // latch after a clear followed by the top n bits of w
  function automatic logic [W-1:0] partial_latch(logic [W-1:0] w, int n);
    logic [W-1:0] r = '1;
    for (int i = 0; i < n; i++) r = {r[W-2:0], w[W-1-i]};
    return r;
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic c, input logic o, input logic vh,
                     input logic va, input logic d);
    ce_n = c; oe = o; vpp_high = vh; vpp_access = va; data_in = d;
    @(negedge clk);
  endtask

  task automatic enter();
    cyc(1, 1, 1, 0, 0);
    cyc(1, 1, 1, 0, 0);
    cyc(1, 1, 0, 1, 0);
  endtask

  task automatic shift_bits(input logic [W-1:0] w, input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, w[W-1-i]);
  endtask

  task automatic step_addr();
    cyc(1, 0, 0, 0, 0);
    e_addr = e_addr + 1'b1;
  endtask

  // R3 R7: clear, load a full word, burn it
  task automatic program_word(input logic [W-1:0] w);
    cyc(0, 1, 0, 0, 0);
    shift_bits(w, W);
    cyc(1, 1, 1, 0, $urandom_range(0, 1));
    e_mem[e_addr] = and_burn(e_mem[e_addr], w);
    cyc(1, 1, 0, 0, 0);
  endtask

  // R4: serial verify of the addressed word
  task automatic read_check(input string req);
    logic [W-1:0] got = '0;
    logic drv = 1'b1;
    for (int k = 0; k < W; k++) begin
      cyc(0, 1, 0, 0, $urandom_range(0, 1));
      got[W-1-k] = data_out;
      drv = drv & data_oe;
    end
    check(got == e_mem[e_addr] && drv, req, got, e_mem[e_addr]);
    cyc(1, 1, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] w1, w2, w3;
    void'($urandom(32'h1f3a_55c7));
    for (int i = 0; i < DEPTH; i++) e_mem[i] = '1;
    e_addr = '0;
    rst_n = 0; ce_n = 1; oe = 1; vpp_high = 0; vpp_access = 0;
    pol_hi = 0; data_in = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(prog_mode == 0, "R9 prog", W'(prog_mode), 0);
    check(data_oe == 0 && data_out == 0, "R9 data", W'({data_oe, data_out}), 0);
    check(chain_out == 1, "R8 chain idle", W'(chain_out), 1);
    rst_n = 1;

    // R10: activity outside the mode does nothing
    for (int i = 0; i < 8; i++) cyc(0, 1, i[0], 0, 1);
    check(data_oe == 0 && prog_mode == 0, "R10 idle pins",
          W'({data_oe, prog_mode}), 0);
    cyc(1, 1, 0, 0, 0);

    // R2: broken sequences
    cyc(1, 1, 1, 0, 0); cyc(1, 1, 0, 1, 0);
    check(prog_mode == 0, "R2 one high edge", W'(prog_mode), 0);
    cyc(1, 1, 1, 0, 0); cyc(0, 1, 1, 0, 0); cyc(1, 1, 0, 1, 0);
    check(prog_mode == 0, "R2 ce dropped", W'(prog_mode), 0);
    cyc(1, 1, 1, 0, 0); cyc(1, 1, 1, 0, 0); cyc(1, 1, 1, 0, 0); cyc(1, 1, 0, 1, 0);
    check(prog_mode == 0, "R2 three high edges", W'(prog_mode), 0);
    cyc(1, 1, 0, 0, 0);

    // R1: proper entry
    enter();
    check(prog_mode == 1, "R1 entry", W'(prog_mode), 1);
    pol_hi = 1; #0.1;
    check(chain_out == 1, "R8 pol high", W'(chain_out), 1);
    pol_hi = 0; #0.1;
    check(chain_out == 0, "R8 pol low", W'(chain_out), 0);

    read_check("R10 word0 still erased");

    // R3 R7: directed then random words
    program_word(32'hA5C3_0F81);
    read_check("R3 R7 directed word");
    for (int n = 0; n < 6; n++) begin
      pol_hi = $urandom_range(0, 1);
      repeat ($urandom_range(1, 3)) step_addr();
      program_word($urandom());
      read_check("R7 random word");
    end
    // R7: a second burn at one address ANDs
    w1 = $urandom();
    program_word(w1);
    program_word(~w1 | 32'h0000_FFFF);
    read_check("R7 double burn");

    // R6: burn of a cleared latch leaves the word alone
    step_addr();
    program_word(32'h1234_5678);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0);
    cyc(1, 1, 0, 0, 0);
    read_check("R6 cleared latch burn");

    // R7: burn on the edge carrying the 32nd bit uses the pre-edge latch
    step_addr();
    w2 = 32'h8F0F_3C3C;
    cyc(0, 1, 0, 0, 0);
    shift_bits(w2, W - 1);
    cyc(1, 1, 1, 0, w2[0]);
    e_mem[e_addr] = and_burn(e_mem[e_addr], partial_latch(w2, W - 1));
    cyc(1, 1, 0, 0, 0);
    read_check("R7 burn with shift");

    // R7 R5: burn on an address-step edge hits the old address
    step_addr();
    w3 = 32'hF00D_BEEF ^ $urandom();
    cyc(0, 1, 0, 0, 0);
    shift_bits(w3, W);
    cyc(1, 0, 1, 0, 0);
    e_mem[e_addr] = and_burn(e_mem[e_addr], w3);
    e_addr = e_addr + 1'b1;
    cyc(1, 1, 0, 0, 0);
    read_check("R5 next address after step");
    for (int i = 0; i < DEPTH - 1; i++) step_addr();
    read_check("R7 R5 burn with step after wrap");

    // R9: reset ends the mode, array retained, address back to 0
    rst_n = 0; @(negedge clk);
    check(prog_mode == 0 && data_oe == 0, "R9 exit",
          W'({prog_mode, data_oe}), 0);
    rst_n = 1;
    e_addr = '0;
    enter();
    check(prog_mode == 1, "R1 re-entry", W'(prog_mode), 1);
    for (int a = 0; a < DEPTH; a++) begin
      read_check("R9 retained");
      step_addr();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule